// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block sits between decode and the functional units of an in-order pipeline. Each cycle it inspects the decoded instruction (a functional-unit class, a destination register, two source registers and a flag saying whether a destination is written). It grants issue only when the required unit class is free, neither source register waits on a result still in flight (read-after-write), and the destination does not already have a result in flight (write-after-write). Because issue and operand read happen in program order, a write-after-read hazard cannot occur and is not checked.

The block keeps two bit-vectors. The first holds one busy bit per unit class; the units drive it directly and the block never writes it. The second holds one write-pending bit per architectural register. Issuing an instruction that writes a destination sets that register's bit. A write-back clears the bit of the written register.

The decoded instruction arrives on a valid/ready pair. `dec_ready` depends only on the instruction fields and the stored state, never on `dec_valid`. An instruction issues on a rising clock edge where both `dec_valid` and `dec_ready` are high. While `dec_ready` is low, decode must hold the instruction and keep `dec_valid` high. The write-back port is a plain strobe with no back-pressure.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset every write-pending bit reads zero, and an instruction whose unit is not busy is granted.
- R2: Unit classes are encoded integer=0, add=1, multiply=2, divide=3, and bit k of `unit_busy` is the busy flag of class k. `dec_ready` is low whenever the busy bit of the selected class is high. Busy bits of other classes have no effect.
- R3: `dec_ready` is low whenever the pending bit of `dec_src1` or of `dec_src2` is set (RAW).
- R4: With `dec_has_dst` high, `dec_ready` is low whenever the pending bit of `dec_dst` is set (WAW).
- R5: No WAR check is made. An instruction whose destination equals one of its own sources, with no bit pending, is granted.
- R6: At an edge with `dec_valid`, `dec_ready` and `dec_has_dst` all high, the pending bit of `dec_dst` reads one after that edge. At an edge with `dec_valid` low, no pending bit changes because of the decode port.
- R7: At an edge with `wb_valid` high, the pending bit of `wb_reg` reads zero after that edge. A write-back does not release a stalled instruction in its own cycle.
- R8: When an issue sets and a write-back clears the same register at one edge, the bit reads one afterwards.
- R9: With `dec_has_dst` low, an issue sets no pending bit, and a pending `dec_dst` causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_ready | output | 1 | Issue grant; instruction may issue this cycle |
| dec_unit | input | 2 | Functional-unit class (0 int, 1 add, 2 mul, 3 div) |
| dec_has_dst | input | 1 | Instruction writes a destination register |
| dec_dst | input | 5 | Destination register index |
| dec_src1 | input | 5 | First source register index |
| dec_src2 | input | 5 | Second source register index |
| unit_busy | input | 4 | Busy flags driven by the functional units, one per class |
| wb_valid | input | 1 | Write-back strobe |
| wb_reg | input | 5 | Register written back |
| pending | output | 32 | Write-pending vector, bit r for register r |

## Verification
The vector walk issues instructions that hit each stall cause on its own: a pending first source, a pending second source, a pending destination, and a busy unit alongside busy flags of the other classes. These show that each hazard check is tied to the correct field and the correct unit bit. Further vectors pair a write-back with a dependent instruction in the same cycle, send a write-back and an issue to one register, issue without a destination onto a pending register, and present an instruction without valid. These separate a registered clear from a bypassed clear, show which side wins a collision, and show that a missing destination and a missing valid each block the set. A second reset in the middle of the run confirms that all pending bits clear.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_UNITS = 4;
  localparam int UNIT_W    = $clog2(NUM_UNITS);

  typedef enum logic [UNIT_W-1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;
endpackage

// File: rtl/sb_pending_table.sv
module sb_pending_table #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_idx,
  output logic [NREG-1:0] pend_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == RW'(r));
    assign hit_clr = clr_en && (clr_idx == RW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_o[r] <= 1'b0;
      else if (hit_set) pend_o[r] <= 1'b1;   // set has priority over clear
      else if (hit_clr) pend_o[r] <= 1'b0;
    end
  end

  p_set_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend_o[$past(set_idx)]);

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !pend_o[$past(clr_idx)]);

  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_en && set_idx == clr_idx) |=> pend_o[$past(clr_idx)]);
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
  import sb_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic [NREG-1:0]      pend,
  input  logic [NUM_UNITS-1:0] unit_busy,
  input  logic [UNIT_W-1:0]    unit,
  input  logic                 has_dst,
  input  logic [RW-1:0]        dst,
  input  logic [RW-1:0]        src1,
  input  logic [RW-1:0]        src2,
  output logic                 unit_stall,
  output logic                 raw_stall,
  output logic                 waw_stall
);
  logic [NUM_UNITS-1:0] unit_sel;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign unit_sel[u] = (unit == UNIT_W'(u)) && unit_busy[u];
  end

  // Only the unit class named by the instruction can stall it.
  assign unit_stall = |unit_sel;
  assign raw_stall  = pend[src1] || pend[src2];
  // WAR is not checked: operands are read in order at issue.
  assign waw_stall  = has_dst && pend[dst];
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dec_valid,
  output logic                 dec_ready,
  input  logic [UNIT_W-1:0]    dec_unit,
  input  logic                 dec_has_dst,
  input  logic [RW-1:0]        dec_dst,
  input  logic [RW-1:0]        dec_src1,
  input  logic [RW-1:0]        dec_src2,
  input  logic [NUM_UNITS-1:0] unit_busy,
  input  logic                 wb_valid,
  input  logic [RW-1:0]        wb_reg,
  output logic [NREG-1:0]      pending
);
  logic unit_stall, raw_stall, waw_stall;
  logic fire, set_en;

  sb_hazard_check #(.NREG(NREG)) u_haz (
    .pend       (pending),
    .unit_busy  (unit_busy),
    .unit       (dec_unit),
    .has_dst    (dec_has_dst),
    .dst        (dec_dst),
    .src1       (dec_src1),
    .src2       (dec_src2),
    .unit_stall (unit_stall),
    .raw_stall  (raw_stall),
    .waw_stall  (waw_stall)
  );

  assign dec_ready = !(unit_stall || raw_stall || waw_stall);
  assign fire      = dec_valid && dec_ready;
  assign set_en    = fire && dec_has_dst;

  sb_pending_table #(.NREG(NREG)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_idx (dec_dst),
    .clr_en  (wb_valid),
    .clr_idx (wb_reg),
    .pend_o  (pending)
  );

  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unit_busy[dec_unit] |-> !dec_ready);

  p_raw_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending[dec_src1] || pending[dec_src2]) |-> !dec_ready);

  p_waw_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_has_dst && pending[dec_dst]) |-> !dec_ready);

  p_no_dst_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_valid && !(dec_valid && dec_has_dst)) |=> pending == $past(pending));
endmodule

// File: tb/issue_scoreboard_test.sv
`timescale 1ns/1ps
module issue_scoreboard_test;
  localparam int NREG = 32;

  typedef struct packed {
    logic       v;
    logic [1:0] unit;
    logic [4:0] dst;
    logic [4:0] s1;
    logic [4:0] s2;
    logic       hd;
    logic [3:0] busy;
    logic       wbv;
    logic [4:0] wbr;
    logic       exp_rdy;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 2'd0, 5'd3,  5'd1,  5'd2,  1'b1, 4'b0000, 1'b0, 5'd0,  1'b1}, // R6 set r3
    '{1'b1, 2'd1, 5'd4,  5'd3,  5'd0,  1'b1, 4'b0000, 1'b0, 5'd0,  1'b0}, // R3 src1
    '{1'b1, 2'd1, 5'd5,  5'd0,  5'd3,  1'b1, 4'b0000, 1'b0, 5'd0,  1'b0}, // R3 src2
    '{1'b1, 2'd2, 5'd3,  5'd6,  5'd7,  1'b1, 4'b0000, 1'b0, 5'd0,  1'b0}, // R4 waw
    '{1'b1, 2'd2, 5'd9,  5'd6,  5'd7,  1'b1, 4'b0100, 1'b0, 5'd0,  1'b0}, // R2 mul busy
    '{1'b1, 2'd2, 5'd9,  5'd6,  5'd7,  1'b1, 4'b1011, 1'b0, 5'd0,  1'b1}, // R2 others busy
    '{1'b1, 2'd3, 5'd9,  5'd10, 5'd11, 1'b0, 4'b0000, 1'b0, 5'd0,  1'b1}, // R9 no dst
    '{1'b1, 2'd0, 5'd12, 5'd12, 5'd12, 1'b1, 4'b0000, 1'b0, 5'd0,  1'b1}, // R5 no war
    '{1'b1, 2'd0, 5'd13, 5'd3,  5'd0,  1'b1, 4'b0000, 1'b1, 5'd3,  1'b0}, // R7 no bypass
    '{1'b1, 2'd0, 5'd13, 5'd3,  5'd0,  1'b1, 4'b0000, 1'b0, 5'd0,  1'b1}, // R7 released
    '{1'b1, 2'd0, 5'd20, 5'd0,  5'd0,  1'b1, 4'b0000, 1'b1, 5'd20, 1'b1}, // R8 collision
    '{1'b0, 2'd0, 5'd21, 5'd0,  5'd0,  1'b1, 4'b0000, 1'b0, 5'd0,  1'b1}, // R6 no valid
    '{1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  1'b0, 4'b0000, 1'b1, 5'd9,  1'b1}, // R7 clear r9
    '{1'b1, 2'd2, 5'd9,  5'd1,  5'd2,  1'b1, 4'b0000, 1'b0, 5'd0,  1'b1}  // R4 reusable
  };

  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid, dec_ready, dec_has_dst, wb_valid;
  logic [1:0] dec_unit;
  logic [4:0] dec_dst, dec_src1, dec_src2, wb_reg;
  logic [3:0] unit_busy;
  logic [NREG-1:0] pending;
  logic [NREG-1:0] model;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  issue_scoreboard #(.NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_unit(dec_unit), .dec_has_dst(dec_has_dst), .dec_dst(dec_dst),
    .dec_src1(dec_src1), .dec_src2(dec_src2), .unit_busy(unit_busy),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .pending(pending)
  );

  task automatic check(input string req, input logic [NREG-1:0] act,
                       input logic [NREG-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_valid = 0; dec_unit = 0; dec_has_dst = 0; dec_dst = 0;
    dec_src1 = 0; dec_src2 = 0; unit_busy = 0; wb_valid = 0; wb_reg = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1: reset state
    check("R1 pending after reset", pending, '0);
    check("R1 ready after reset", NREG'(dec_ready), NREG'(1));
    model = '0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dec_valid = VEC[i].v; dec_unit = VEC[i].unit; dec_dst = VEC[i].dst;
      dec_src1 = VEC[i].s1; dec_src2 = VEC[i].s2; dec_has_dst = VEC[i].hd;
      unit_busy = VEC[i].busy; wb_valid = VEC[i].wbv; wb_reg = VEC[i].wbr;
      #1;
      check($sformatf("R2-5 ready vec%0d", i), NREG'(dec_ready), NREG'(VEC[i].exp_rdy));
      if (VEC[i].wbv) model[VEC[i].wbr] = 1'b0;
      if (VEC[i].v && VEC[i].exp_rdy && VEC[i].hd) model[VEC[i].dst] = 1'b1;
      @(negedge clk);
      idle();
      #1;
      check($sformatf("R6 R7 R8 R9 pending vec%0d", i), pending, model);
    end

    // R2: every unit class blocked by its own busy bit only
    for (int u = 0; u < 4; u++) begin
      @(negedge clk);
      dec_valid = 0; dec_unit = 2'(u); dec_src1 = 5'd30; dec_src2 = 5'd31;
      dec_has_dst = 1; dec_dst = 5'd29;
      unit_busy = 4'(1 << u);
      #1;
      check($sformatf("R2 own busy unit%0d", u), NREG'(dec_ready), NREG'(0));
      unit_busy = ~4'(1 << u);
      #1;
      check($sformatf("R2 other busy unit%0d", u), NREG'(dec_ready), NREG'(1));
    end
    @(negedge clk);
    idle();
    #1;
    check("R6 ready without valid sets nothing", pending, model);

    // R1: reset mid-run clears all pending bits
    rst_n = 0;
    #1;
    check("R1 async reset clears", pending, '0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    check("R1 pending after second reset", pending, '0);

    done = 1;
    finish_run();
  end
endmodule